// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Unit with Exact Residual

The block accepts a stream of 32-bit single-precision values and returns, for each one, the 16-bit half-precision value nearest to it (ties go to the even neighbour). Alongside the narrowed value it returns a residual: the exact single-precision difference between the input and the half value widened back to single. A downstream multiplier can then split an operand into its half part and a residual part. It multiplies both parts and sums the partial products to recover the accuracy that narrowing threw away.

Each input is classified before it is narrowed. Values beyond the half range saturate to a signed infinity and raise an overflow flag. Values too small to reach the smallest half subnormal collapse to a signed zero, and their residual carries the whole input. NaN inputs produce a quiet half NaN and raise an invalid flag. The block takes one value per cycle on a valid/ready input and has two register stages. A full output that is not taken stalls the whole pipe.

Top module: `halfNarrowResidual`

## Requirements
- R1: The half output packs sign in bit 15, a 5-bit biased exponent (bias 15) in bits 14:10 and a 10-bit fraction in bits 9:0. A finite input inside the half range is rounded to the nearest half value. For an input with unbiased exponent e the rounding step is 2^(e-10).
- R2: When an input lies exactly midway between two half values, the half value whose fraction LSB is 0 is chosen.
- R3: If the rounded magnitude exceeds 65504 (half 0x7BFF), or the input is an infinity, the half output is a signed infinity (bits 14:0 = 0x7C00). The overflow flag is then 1 and the residual is 0x00000000. 65504 itself and values that round down to it stay finite.
- R4: If the input rounds to zero, the half output is a zero with the input's sign and the residual equals the input bit for bit. This covers single-precision zeros and subnormals.
- R5: Inputs below 2^-14 in magnitude that do not round to zero give half subnormal outputs (exponent field 0) with rounding step 2^-24. A rounding carry into 2^-14 gives exponent field 1.
- R6: For finite, non-overflowing results the residual is exactly input minus the widened half value, with no rounding. An exact conversion gives +0 (0x00000000). The residual magnitude never exceeds half the rounding step at the input's exponent.
- R7: A NaN input (exponent all ones, fraction nonzero) gives half {sign, 0x1F, 0x200}. The residual is 0x00000000, the invalid flag is 1 and the overflow flag is 0.
- R8: `inReady` is high whenever the output is empty or is being taken. One value can be accepted every cycle. A value accepted at rising edge N appears on the outputs, with `outValid` high, just after edge N+1.
- R9: While `outValid` is high and `outReady` is low, every output holds its value and `inReady` is low.
- R10: While reset is asserted and after it is released, with no input, `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input value present |
| inReady | output | 1 | Block can take an input this cycle |
| inData | input | 32 | Single-precision input value |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result this cycle |
| outHalf | output | 16 | Rounded half-precision value |
| outResidual | output | 32 | Single-precision residual, input minus widened half |
| outOverflow | output | 1 | Result saturated to infinity |
| outInvalid | output | 1 | Input was a NaN |

## Verification
Every result is due on the falling edge that follows the second rising edge after its acceptance edge: one edge loads stage one and the next loads the output register. The vector table is streamed one value per cycle. Each vector's half value, residual, flags and valid bit are compared two falling edges after the edge on which it is driven. In the stall sequence the outputs are sampled over several held cycles and again on the first falling edge after `outReady` returns. This shows that a stalled result neither advances nor changes.

// File: rtl/halfNarrowPkg.sv
package halfNarrowPkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int SP_BIAS   = 127;
  localparam int HP_W      = 16;
  localparam int HP_EXP_W  = 5;
  localparam int HP_MAN_W  = 10;
  localparam int HP_BIAS   = 15;
  localparam int SIG_W     = SP_MAN_W + 1;
  localparam int DROP_NORM = SP_MAN_W - HP_MAN_W;
  localparam int SHIFT_MAX = SIG_W + 1;
  localparam int LEAD_W    = $clog2(SIG_W);
  localparam int EXP_E_W   = SP_EXP_W + 2;

  typedef struct packed {
    logic load1;
    logic load2;
  } pipeStrobe_t;

  typedef struct packed {
    logic                sign;
    logic                isNan;
    logic                isOvf;
    logic                isZeroOut;
    logic [HP_W-2:0]     mag;
    logic [SP_W-1:0]     raw;
    logic                residNeg;
    logic [SIG_W-1:0]    residMag;
    logic [SP_EXP_W-1:0] residExpBase;
  } stage1_t;
endpackage

// File: rtl/halfNarrowCtrl.sv
module halfNarrowCtrl
  import halfNarrowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output pipeStrobe_t strobe
);
  logic valid1;
  logic valid2;
  logic advance;

  assign advance  = !valid2 || outReady;
  assign inReady  = advance;
  assign outValid = valid2;

  always_comb begin
    strobe.load1 = advance && inValid;
    strobe.load2 = advance && valid1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
    end else if (advance) begin
      valid1 <= inValid;
      valid2 <= valid1;
    end
  end
endmodule

// File: rtl/halfNarrowDatapath.sv
module halfNarrowDatapath
  import halfNarrowPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  pipeStrobe_t     strobe,
  input  logic [SP_W-1:0] inData,
  output logic [HP_W-1:0] outHalf,
  output logic [SP_W-1:0] outResidual,
  output logic            outOverflow,
  output logic            outInvalid
);
  localparam logic signed [EXP_E_W-1:0] MIN_NORM_E = EXP_E_W'(1 - HP_BIAS);
  localparam logic signed [EXP_E_W-1:0] SP_BIAS_S  = EXP_E_W'(SP_BIAS);
  localparam logic signed [EXP_E_W-1:0] FLUSH_E    = EXP_E_W'(-(SHIFT_MAX + 1));
  localparam logic signed [EXP_E_W-1:0] MAN_SHIFT  = EXP_E_W'(HP_MAN_W);
  localparam logic signed [EXP_E_W-1:0] RES_OFFS   = EXP_E_W'(SP_BIAS - SIG_W);
  localparam int MAG_W = 2 * SIG_W;
  localparam logic [MAG_W-1:0] INF_MAG = MAG_W'(((1 << HP_EXP_W) - 1) << HP_MAN_W);
  localparam logic [HP_W-2:0] INF_CODE = (HP_W-1)'(((1 << HP_EXP_W) - 1) << HP_MAN_W);
  localparam logic [HP_W-2:0] QNAN_CODE = INF_CODE | (HP_W-1)'(1 << (HP_MAN_W - 1));

  // ---------------- stage 1: classify, align, round ----------------
  logic                       sign;
  logic [SP_EXP_W-1:0]        expF;
  logic [SP_MAN_W-1:0]        man;
  logic                       nanIn;
  logic                       infIn;
  logic signed [EXP_E_W-1:0]  eUnb;
  logic signed [EXP_E_W-1:0]  qExp;
  logic [$clog2(SHIFT_MAX+1)-1:0] shAmt;
  logic [SIG_W-1:0]           sig;
  logic [2*SIG_W-1:0]         wide;
  logic [SIG_W-1:0]           kept;
  logic                       guardBit;
  logic                       stickyBit;
  logic                       roundUp;
  logic [SIG_W-1:0]           rnd;
  logic [EXP_E_W-1:0]         hpExpBase;
  logic [MAG_W-1:0]           magWide;
  logic [SIG_W-1:0]           residLow;
  stage1_t                    s1D;
  stage1_t                    s1Q;

  always_comb begin
    sign  = inData[SP_W-1];
    expF  = inData[SP_W-2 -: SP_EXP_W];
    man   = inData[SP_MAN_W-1:0];
    nanIn = (&expF) && (|man);
    infIn = (&expF) && !(|man);
    eUnb  = $signed({2'b00, expF}) - SP_BIAS_S;
    sig   = {|expF, man};

    if (eUnb >= MIN_NORM_E) begin
      shAmt     = ($clog2(SHIFT_MAX+1))'(DROP_NORM);
      hpExpBase = EXP_E_W'(eUnb - MIN_NORM_E);
      qExp      = eUnb - MAN_SHIFT;
    end else begin
      if (eUnb <= FLUSH_E) shAmt = ($clog2(SHIFT_MAX+1))'(SHIFT_MAX);
      else                 shAmt = ($clog2(SHIFT_MAX+1))'(-eUnb - 1);
      hpExpBase = '0;
      qExp      = MIN_NORM_E - MAN_SHIFT;
    end

    wide      = {sig, {SIG_W{1'b0}}} >> shAmt;
    kept      = wide[2*SIG_W-1:SIG_W];
    residLow  = wide[SIG_W-1:0];
    guardBit  = residLow[SIG_W-1];
    stickyBit = |residLow[SIG_W-2:0];
    roundUp   = guardBit && (stickyBit || kept[0]);
    rnd       = kept + SIG_W'(roundUp);
    magWide   = (MAG_W'(hpExpBase) << HP_MAN_W) + MAG_W'(rnd);

    s1D.sign         = sign;
    s1D.isNan        = nanIn;
    s1D.isOvf        = !nanIn && (infIn || (magWide >= INF_MAG));
    s1D.isZeroOut    = (rnd == '0);
    s1D.mag          = magWide[HP_W-2:0];
    s1D.raw          = inData;
    s1D.residNeg     = sign ^ roundUp;
    s1D.residMag     = roundUp ? (~residLow + SIG_W'(1)) : residLow;
    s1D.residExpBase = SP_EXP_W'(qExp + RES_OFFS);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             s1Q <= '0;
    else if (strobe.load1) s1Q <= s1D;
  end

  // ---------------- stage 2: normalise residual, select ----------------
  logic [LEAD_W-1:0]    lead;
  logic [SP_MAN_W-1:0]  resMan;
  logic [SP_EXP_W-1:0]  resExp;
  logic [SP_W-1:0]      residD;
  logic [HP_W-1:0]      halfD;

  always_comb begin
    lead = '0;
    for (int i = 0; i < SIG_W; i++) begin
      if (s1Q.residMag[i]) lead = LEAD_W'(i);
    end
    resMan = SP_MAN_W'(s1Q.residMag << (LEAD_W'(SIG_W - 1) - lead));
    resExp = s1Q.residExpBase + SP_EXP_W'(lead);

    if (s1Q.isNan || s1Q.isOvf)  residD = '0;
    else if (s1Q.isZeroOut)      residD = s1Q.raw;
    else if (s1Q.residMag == '0) residD = '0;
    else                         residD = {s1Q.residNeg, resExp, resMan};

    if (s1Q.isNan)      halfD = {s1Q.sign, QNAN_CODE};
    else if (s1Q.isOvf) halfD = {s1Q.sign, INF_CODE};
    else                halfD = {s1Q.sign, s1Q.mag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outHalf     <= '0;
      outResidual <= '0;
      outOverflow <= 1'b0;
      outInvalid  <= 1'b0;
    end else if (strobe.load2) begin
      outHalf     <= halfD;
      outResidual <= residD;
      outOverflow <= s1Q.isOvf;
      outInvalid  <= s1Q.isNan;
    end
  end
endmodule

// File: rtl/halfNarrowResidual.sv
module halfNarrowResidual
  import halfNarrowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  output logic        outValid,
  input  logic        outReady,
  output logic [15:0] outHalf,
  output logic [31:0] outResidual,
  output logic        outOverflow,
  output logic        outInvalid
);
  pipeStrobe_t strobe;

  halfNarrowCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  halfNarrowDatapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inData      (inData),
    .outHalf     (outHalf),
    .outResidual (outResidual),
    .outOverflow (outOverflow),
    .outInvalid  (outInvalid)
  );
endmodule

// File: rtl/halfNarrowChecker.sv
module halfNarrowChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [15:0] outHalf,
  input logic [31:0] outResidual,
  input logic        outOverflow,
  input logic        outInvalid
);
  logic [7:0] resExpLimit;
  assign resExpLimit = (outHalf[14:10] == 5'd0) ? 8'd102 : (8'(outHalf[14:10]) + 8'd101);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outHalf) && $stable(outResidual) && $stable(outOverflow) && $stable(outInvalid)); // R9

  AST_OVF_INF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outOverflow |-> outHalf[14:0] == 15'h7C00 && outResidual == 32'd0 && !outInvalid); // R3

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outInvalid |-> outHalf[14:0] == 15'h7E00 && outResidual == 32'd0 && !outOverflow); // R7

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady); // R8

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> ##1 outValid); // R8

  AST_RESID_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outOverflow && !outInvalid && outHalf[14:0] != 15'd0 && outResidual[30:0] != 31'd0
    |-> outResidual[30:23] <= resExpLimit); // R6
endmodule

bind halfNarrowResidual halfNarrowChecker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inReady     (inReady),
  .outValid    (outValid),
  .outReady    (outReady),
  .outHalf     (outHalf),
  .outResidual (outResidual),
  .outOverflow (outOverflow),
  .outInvalid  (outInvalid)
);

// File: tb/halfNarrowResidual_tb_top.sv
module halfNarrowResidual_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [15:0] outHalf;
  logic [31:0] outResidual;
  logic        outOverflow;
  logic        outInvalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  halfNarrowResidual dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outHalf(outHalf),
    .outResidual(outResidual), .outOverflow(outOverflow), .outInvalid(outInvalid)
  );

  typedef struct packed {
    logic [31:0] din;
    logic [15:0] half;
    logic [31:0] res;
    logic        ovf;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 16'h3C00, 32'h00000000, 1'b0, 1'b0, 4'd1},  // R1 1.0
    '{32'hC0200000, 16'hC100, 32'h00000000, 1'b0, 1'b0, 4'd1},  // R1 -2.5
    '{32'h40490FDB, 16'h4248, 32'h3A7DB000, 1'b0, 1'b0, 4'd6},  // R6 pi, round down
    '{32'h3F801000, 16'h3C00, 32'h3A000000, 1'b0, 1'b0, 4'd2},  // R2 tie, stays even
    '{32'h3F803000, 16'h3C02, 32'hBA000000, 1'b0, 1'b0, 4'd2},  // R2 tie, odd -> up
    '{32'h3F800800, 16'h3C00, 32'h39800000, 1'b0, 1'b0, 4'd6},  // R6 below tie
    '{32'h3F801008, 16'h3C01, 32'hB9FF8000, 1'b0, 1'b0, 4'd6},  // R6 above tie, neg resid
    '{32'h477FE000, 16'h7BFF, 32'h00000000, 1'b0, 1'b0, 4'd3},  // R3 65504 exact
    '{32'h477FEF00, 16'h7BFF, 32'h41700000, 1'b0, 1'b0, 4'd3},  // R3 65519 -> 65504, resid 15
    '{32'h477FF000, 16'h7C00, 32'h00000000, 1'b1, 1'b0, 4'd3},  // R3 65520 -> inf
    '{32'hC9800000, 16'hFC00, 32'h00000000, 1'b1, 1'b0, 4'd3},  // R3 -2^20
    '{32'h7F800000, 16'h7C00, 32'h00000000, 1'b1, 1'b0, 4'd3},  // R3 +inf in
    '{32'h7FC00001, 16'h7E00, 32'h00000000, 1'b0, 1'b1, 4'd7},  // R7 quiet NaN
    '{32'hFF800001, 16'hFE00, 32'h00000000, 1'b0, 1'b1, 4'd7},  // R7 signalling NaN, neg
    '{32'h33800000, 16'h0001, 32'h00000000, 1'b0, 1'b0, 4'd5},  // R5 2^-24
    '{32'hB3400000, 16'h8001, 32'h32800000, 1'b0, 1'b0, 4'd5},  // R5 -1.5*2^-25
    '{32'h387FF000, 16'h0400, 32'hB2800000, 1'b0, 1'b0, 4'd5},  // R5 carry into normal
    '{32'h38800000, 16'h0400, 32'h00000000, 1'b0, 1'b0, 4'd1},  // R1 2^-14
    '{32'h33000000, 16'h0000, 32'h33000000, 1'b0, 1'b0, 4'd4},  // R4 2^-25 tie -> 0
    '{32'h00000001, 16'h0000, 32'h00000001, 1'b0, 1'b0, 4'd4},  // R4 single subnormal
    '{32'h80000000, 16'h8000, 32'h80000000, 1'b0, 1'b0, 4'd4},  // R4 -0
    '{32'hB2000000, 16'h8000, 32'hB2000000, 1'b0, 1'b0, 4'd4}   // R4 -2^-27
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkVec(input vec_t v, input string where);
    string tag;
    tag = $sformatf("R%0d %s in=%h", v.req, where, v.din);
    chk({tag, " valid"}, 32'(outValid), 32'd1);
    chk({tag, " half"}, 32'(outHalf), 32'(v.half));
    chk({tag, " residual"}, outResidual, v.res);
    chk({tag, " flags"}, 32'({outOverflow, outInvalid}), 32'({v.ovf, v.inv}));
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finishRun();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 outValid in reset", 32'(outValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 outValid after reset", 32'(outValid), 32'd0);
    chk("R8 inReady when empty", 32'(inReady), 32'd1);

    // Table streamed one value per cycle (R8 throughput and latency)
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) chkVec(VECS[k-2], "stream");
      if (k < NV) begin
        inValid = 1'b1;
        inData  = VECS[k].din;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8 outValid drains", 32'(outValid), 32'd0);

    // Stall sequence (R9)
    outReady = 1'b0;
    inValid  = 1'b1;
    inData   = VECS[0].din;        // A accepted at next edge
    @(negedge clk);
    inData   = VECS[2].din;        // B accepted at next edge
    @(negedge clk);
    inData   = VECS[12].din;       // C waits
    chkVec(VECS[0], "stall first");
    chk("R9 inReady low while stalled", 32'(inReady), 32'd0);
    repeat (3) @(negedge clk);
    chkVec(VECS[0], "stall held");
    chk("R9 inReady still low", 32'(inReady), 32'd0);
    outReady = 1'b1;
    #1;
    chk("R8 inReady follows outReady", 32'(inReady), 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    chkVec(VECS[2], "after stall B");
    @(negedge clk);
    chkVec(VECS[12], "after stall C");
    @(negedge clk);
    chk("R8 empty after stall", 32'(outValid), 32'd0);

    // R10: reset in mid-stream clears valid
    inValid = 1'b1;
    inData  = VECS[1].din;
    @(negedge clk);
    inValid = 1'b0;
    rstN    = 1'b0;
    @(negedge clk);
    rstN    = 1'b1;
    @(negedge clk);
    chk("R10 reset flushes pipe", 32'(outValid), 32'd0);

    finishRun();
  end
endmodule